// File: doc/BRIEF.md
# Streaming Sector Hamming ECC Engine

This engine protects 512-byte data sectors with a single-error-correcting parity code. The code is built on the fly while bytes move through the block at one byte per cycle, so no second pass over the data is needed. In write mode, the sector bytes pass straight to the output. A 16-byte spare area follows them. The spare area starts with the check bytes and is padded with 0xFF. Nothing is read back to verify the write.

In read mode, the engine takes in the whole 528-byte unit (sector plus spare area) before it emits anything. It stores the sector in an internal buffer and forms a syndrome from the recomputed code and the stored check bytes. It then does one of two things:

- It streams out the sector, with at most one data bit repaired, and reports whether a repair was made.
- It reports that the unit cannot be corrected and sends no data at all.

Both sides use byte-wide valid/ready handshakes. The operating mode is taken from `mode_rd` when a frame begins.

Top module: `sec_ecc_engine`

## Requirements
- R1: While reset is held and immediately after it is released, `out_valid`, `in_ready`, `st_ok`, `st_fixed` and `st_bad` are all 0.
- R2: In write mode, the 512 sector bytes leave on the output unchanged and in order. `in_ready` follows `out_ready` during this phase, so an accepted input byte is the output byte of the same cycle.
- R3: In write mode, exactly 16 spare bytes follow the sector. Spare bytes 0, 1 and 2 carry code bits [7:0], [15:8] and [23:16]. Spare bytes 3 to 15 are 0xFF.
- R4: The 24-bit code is defined as follows. Bits 0 to 17 are line parity: for each byte address bit k (0..8), bit 2k is the XOR of every data bit in bytes whose address has bit k clear, and bit 2k+1 is the same for bytes whose address has bit k set. Bits 18 to 23 are column parity: for each bit-position bit k (0..2), bit 18+2k is the XOR of the data bits in positions with bit k clear over the whole sector, and bit 19+2k is the same for positions with bit k set.
- R5: In read mode, `in_ready` stays high until all 528 bytes have been accepted. `out_valid` stays low throughout that phase.
- R6: If the syndrome (recomputed code XOR stored code) is zero, the 512 bytes are output unchanged. `st_ok` is high for exactly the one cycle after the last output byte is accepted.
- R7: If every syndrome pair (bits 2k, 2k+1) has exactly one bit set, the single data bit at byte address {odd line bits} and bit position {odd column bits} is inverted in the output. `st_fixed` is high for the one cycle after the last output byte.
- R8: If the syndrome has exactly one bit set, the error is in the check bytes. The data is output unchanged and `st_fixed` is reported.
- R9: Any other syndrome produces no output bytes. `st_bad` is high for one cycle shortly after the last spare byte is accepted.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold steady into the next cycle.
- R11: In read mode, spare bytes 3 to 15 have no effect on the data or the status.
- R12: `mode_rd` is sampled while the engine is idle and `in_valid` is high: 1 selects read, 0 selects write. Write frames report no status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_rd | input | 1 | Frame mode: 1 read/correct, 0 write/encode |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Engine accepts input byte |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts output byte |
| out_data | output | 8 | Output byte |
| st_ok | output | 1 | Read frame clean, one-cycle pulse |
| st_fixed | output | 1 | Read frame corrected, one-cycle pulse |
| st_bad | output | 1 | Read frame uncorrectable, one-cycle pulse |

## Verification
The bench injects single-bit errors at the first bit of byte 0, at the top bit of byte 511 and in the middle of the sector. An error in address decoding would flip the wrong byte, and a swapped line or column pair would repair the wrong bit position. It corrupts one check bit to confirm that data is not touched in that case; a design that treated any nonzero syndrome as a data error would corrupt a good sector. A double error must yield `st_bad` with zero bytes out; a design that passed data on regardless would leak unverified bytes. It also checks that random backpressure never changes a held byte and that garbage in the padding bytes leaves a clean read clean.

// File: rtl/sec_ecc_pkg.sv
package sec_ecc_pkg;

  localparam int COL_PAIRS = 3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WDATA, ST_WSPARE, ST_RLOAD, ST_RCHECK, ST_RSEND
  } sec_state_e;

  typedef enum logic [1:0] {
    SYN_CLEAN, SYN_DATA, SYN_CHECK, SYN_BAD
  } syn_cls_e;

  // Column parity contribution of one byte: pair k splits bit positions by bit k
  function automatic logic [2*COL_PAIRS-1:0] col_term(input logic [7:0] d);
    logic [2*COL_PAIRS-1:0] t;
    t = '0;
    for (int k = 0; k < COL_PAIRS; k++) begin
      for (int j = 0; j < 8; j++) begin
        if (((j >> k) & 1) == 1) t[2*k+1] = t[2*k+1] ^ d[j];
        else                     t[2*k]   = t[2*k]   ^ d[j];
      end
    end
    return t;
  endfunction

endpackage

// File: rtl/sec_ecc_acc.sv
module sec_ecc_acc
  import sec_ecc_pkg::*;
#(
  parameter int AW = 9,
  parameter int CW = 2*AW + 2*COL_PAIRS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic [AW-1:0] idx,
  input  logic [7:0]    din,
  output logic [CW-1:0] code
);

  // Line parity contribution: byte parity lands in lo or hi of each address-bit pair
  function automatic logic [2*AW-1:0] line_term(input logic [AW-1:0] a, input logic p);
    logic [2*AW-1:0] t;
    for (int k = 0; k < AW; k++) begin
      t[2*k]   = p & ~a[k];
      t[2*k+1] = p &  a[k];
    end
    return t;
  endfunction

  logic [CW-1:0] step;
  assign step = {col_term(din), line_term(idx, ^din)};

  always_ff @(posedge clk) begin
    if (!rst_n)    code <= '0;
    else if (clr)  code <= '0;
    else if (en)   code <= code ^ step;
  end

  // R4
  acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !en) |=> (code == '0));

endmodule

// File: rtl/sec_ecc_syn.sv
module sec_ecc_syn
  import sec_ecc_pkg::*;
#(
  parameter int AW = 9,
  parameter int CW = 2*AW + 2*COL_PAIRS
) (
  input  logic [CW-1:0] calc,
  input  logic [CW-1:0] stored,
  output syn_cls_e      cls,
  output logic [AW-1:0] err_byte,
  output logic [2:0]    err_bit
);

  localparam int PAIRS = CW / 2;

  function automatic logic all_pairs_split(input logic [CW-1:0] s);
    logic r;
    r = 1'b1;
    for (int k = 0; k < PAIRS; k++) r = r & (s[2*k] ^ s[2*k+1]);
    return r;
  endfunction

  logic [CW-1:0] syn;
  logic          split;
  logic          lone;

  assign syn   = calc ^ stored;
  assign split = all_pairs_split(syn);
  assign lone  = ($countones(syn) == 1);

  always_comb begin
    for (int k = 0; k < AW; k++) err_byte[k] = syn[2*k+1];
    for (int k = 0; k < 3; k++)  err_bit[k]  = syn[2*AW+2*k+1];
  end

  always_comb begin
    if (syn == '0)   cls = SYN_CLEAN;
    else if (split)  cls = SYN_DATA;
    else if (lone)   cls = SYN_CHECK;
    else             cls = SYN_BAD;
  end

  // R7
  always_comb begin
    data_weight_chk: assert (cls != SYN_DATA || $countones(syn) == PAIRS);
  end

endmodule

// File: rtl/sec_ecc_buf.sv
module sec_ecc_buf #(
  parameter int DEPTH = 512,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/sec_ecc_engine.sv
module sec_ecc_engine
  import sec_ecc_pkg::*;
#(
  parameter int SECT_BYTES  = 512,
  parameter int SPARE_BYTES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_rd,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       st_ok,
  output logic       st_fixed,
  output logic       st_bad
);

  localparam int AW         = $clog2(SECT_BYTES);
  localparam int CW         = 2*AW + 2*COL_PAIRS;
  localparam int CODE_BYTES = (CW + 7) / 8;
  localparam int TOTAL      = SECT_BYTES + SPARE_BYTES;
  localparam int CNTW       = $clog2(TOTAL);
  localparam logic [CNTW-1:0] LAST_DATA  = CNTW'(SECT_BYTES - 1);
  localparam logic [CNTW-1:0] LAST_SPARE = CNTW'(SPARE_BYTES - 1);
  localparam logic [CNTW-1:0] LAST_ALL   = CNTW'(TOTAL - 1);
  localparam logic [CNTW-1:0] SECT_CNT   = CNTW'(SECT_BYTES);

  sec_state_e            state;
  logic [CNTW-1:0]       cnt;
  logic [CODE_BYTES*8-1:0] stored_q;
  logic [CODE_BYTES*8-1:0] code_pad;
  logic [CW-1:0]         acc_code;
  logic                  fix_data_q, fixed_q;
  logic [AW-1:0]         err_byte_q, err_byte_w;
  logic [2:0]            err_bit_q, err_bit_w;
  syn_cls_e              syn_cls;
  logic [7:0]            rd_byte, spare_byte, flip_mask;

  // named events for assertions
  logic in_fire, out_fire, in_sector, sec_done, spare_done, load_done;
  logic [CNTW-1:0] sidx;

  assign in_fire    = in_valid && in_ready;
  assign out_fire   = out_valid && out_ready;
  assign in_sector  = (cnt < SECT_CNT);
  assign sidx       = cnt - SECT_CNT;
  assign sec_done   = (state == ST_RSEND) && out_fire && (cnt == LAST_DATA);
  assign spare_done = (state == ST_WSPARE) && out_fire && (cnt == LAST_SPARE);
  assign load_done  = (state == ST_RLOAD) && in_fire && (cnt == LAST_ALL);

  sec_ecc_acc #(.AW(AW), .CW(CW)) u_acc (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (state == ST_IDLE),
    .en   (in_fire && in_sector && (state == ST_WDATA || state == ST_RLOAD)),
    .idx  (cnt[AW-1:0]),
    .din  (in_data),
    .code (acc_code)
  );

  sec_ecc_buf #(.DEPTH(SECT_BYTES), .AW(AW)) u_buf (
    .clk  (clk),
    .we   ((state == ST_RLOAD) && in_fire && in_sector),
    .waddr(cnt[AW-1:0]),
    .wdata(in_data),
    .raddr(cnt[AW-1:0]),
    .rdata(rd_byte)
  );

  sec_ecc_syn #(.AW(AW), .CW(CW)) u_syn (
    .calc    (acc_code),
    .stored  (stored_q[CW-1:0]),
    .cls     (syn_cls),
    .err_byte(err_byte_w),
    .err_bit (err_bit_w)
  );

  always_comb begin
    code_pad = '1;
    code_pad[CW-1:0] = acc_code;
    spare_byte = 8'hFF;
    for (int b = 0; b < CODE_BYTES; b++)
      if (cnt == CNTW'(b)) spare_byte = code_pad[b*8 +: 8];
  end

  assign flip_mask = (fix_data_q && cnt[AW-1:0] == err_byte_q) ? (8'd1 << err_bit_q) : 8'd0;

  always_comb begin
    in_ready  = 1'b0;
    out_valid = 1'b0;
    out_data  = 8'h00;
    case (state)
      ST_WDATA: begin
        in_ready  = out_ready;
        out_valid = in_valid;
        out_data  = in_data;
      end
      ST_WSPARE: begin
        out_valid = 1'b1;
        out_data  = spare_byte;
      end
      ST_RLOAD: in_ready = 1'b1;
      ST_RSEND: begin
        out_valid = 1'b1;
        out_data  = rd_byte ^ flip_mask;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      stored_q   <= '0;
      fix_data_q <= 1'b0;
      fixed_q    <= 1'b0;
      err_byte_q <= '0;
      err_bit_q  <= '0;
      st_ok      <= 1'b0;
      st_fixed   <= 1'b0;
      st_bad     <= 1'b0;
    end else begin
      st_ok    <= 1'b0;
      st_fixed <= 1'b0;
      st_bad   <= 1'b0;
      case (state)
        ST_IDLE: begin
          cnt      <= '0;
          stored_q <= '0;
          if (in_valid) state <= mode_rd ? ST_RLOAD : ST_WDATA;
        end
        ST_WDATA: if (in_fire) begin
          if (cnt == LAST_DATA) begin
            cnt   <= '0;
            state <= ST_WSPARE;
          end else cnt <= cnt + 1'b1;
        end
        ST_WSPARE: if (out_fire) begin
          if (spare_done) begin
            cnt   <= '0;
            state <= ST_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        ST_RLOAD: if (in_fire) begin
          for (int b = 0; b < CODE_BYTES; b++)
            if (!in_sector && sidx == CNTW'(b)) stored_q[b*8 +: 8] <= in_data;
          if (load_done) begin
            cnt   <= '0;
            state <= ST_RCHECK;
          end else cnt <= cnt + 1'b1;
        end
        ST_RCHECK: begin
          if (syn_cls == SYN_BAD) begin
            st_bad <= 1'b1;
            state  <= ST_IDLE;
          end else begin
            fix_data_q <= (syn_cls == SYN_DATA);
            fixed_q    <= (syn_cls != SYN_CLEAN);
            err_byte_q <= err_byte_w;
            err_bit_q  <= err_bit_w;
            state      <= ST_RSEND;
          end
        end
        ST_RSEND: if (out_fire) begin
          if (sec_done) begin
            st_ok    <= !fixed_q;
            st_fixed <= fixed_q;
            cnt      <= '0;
            state    <= ST_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && state != ST_WDATA) |=> (out_valid && $stable(out_data)));

  // R6
  status_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({st_ok, st_fixed, st_bad}));

  // R6
  status_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_ok || st_fixed) |-> $past(sec_done));

  // R9
  bad_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RCHECK && syn_cls == SYN_BAD) |=> (st_bad && !out_valid));

  // R5
  load_then_check_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> (state == ST_RCHECK && !out_valid));

  // R3
  spare_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spare_done |=> (state == ST_IDLE && !out_valid));

endmodule

// File: tb/sim_sec_ecc_engine.sv
module sim_sec_ecc_engine;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_rd = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       out_ready = 1'b1;
  logic       in_ready, out_valid, st_ok, st_fixed, st_bad;
  logic [7:0] out_data;

  sec_ecc_engine u0 (
    .clk(clk), .rst_n(rst_n), .mode_rd(mode_rd),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .st_ok(st_ok), .st_fixed(st_fixed), .st_bad(st_bad)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_fire_cyc = 0;
  int stat_cyc = 0;
  int stat_kind = 0;
  int stat_count = 0;
  bit bp_en = 1'b0;
  bit loading = 1'b0;
  bit out_during_load = 1'b0;
  bit hold_pending = 1'b0;
  logic [7:0] held_byte = 8'h00;
  logic [7:0] got[$];
  logic [7:0] dat_a[$];
  logic [7:0] dat_b[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // downstream readiness
  initial forever begin
    @(negedge clk);
    out_ready = bp_en ? (($urandom % 4) != 0) : 1'b1;
  end

  // monitor, sampled mid-cycle
  always @(negedge clk) begin
    #2;
    cyc++;
    if (rst_n) begin
      if (hold_pending) begin
        checks++;
        if (!(out_valid && out_data == held_byte)) begin
          errors++;
          $display("FAIL R10 actual=%0d/%0d expected=1/%0d", out_valid, out_data, held_byte);
        end
      end
      hold_pending = out_valid && !out_ready;
      held_byte = out_data;
      if (out_valid && out_ready) begin
        got.push_back(out_data);
        last_fire_cyc = cyc;
      end
      if (st_ok || st_fixed || st_bad) begin
        stat_count++;
        stat_cyc = cyc;
        stat_kind = st_ok ? 1 : (st_fixed ? 2 : 3);
      end
      if (loading && out_valid) out_during_load = 1'b1;
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // reference code: each set data bit toggles one bit of every pair
  function automatic logic [23:0] ref_code(input logic [7:0] q[$]);
    logic [23:0] c = '0;
    for (int i = 0; i < 512; i++)
      for (int j = 0; j < 8; j++)
        if (q[i][j]) begin
          for (int k = 0; k < 9; k++) c[2*k + ((i >> k) & 1)] ^= 1'b1;
          for (int k = 0; k < 3; k++) c[18 + 2*k + ((j >> k) & 1)] ^= 1'b1;
        end
    return c;
  endfunction

  task automatic send_frame(input bit rd, input logic [7:0] q[$]);
    int i = 0;
    mode_rd = rd;
    while (i < q.size()) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = q[i];
      #1;
      if (in_ready) i++;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] d[$], input bit bp, input string tag);
    logic [23:0] c;
    bit same;
    c = ref_code(d);
    got.delete();
    stat_count = 0;
    bp_en = bp;
    send_frame(1'b0, d);
    for (int w = 0; w < 3000 && got.size() < 528; w++) @(negedge clk);
    repeat (4) @(negedge clk);
    bp_en = 1'b0;
    check(got.size() == 528, {tag, " R12 write length"}, got.size(), 528);
    if (got.size() == 528) begin
      same = 1'b1;
      for (int i = 0; i < 512; i++) if (got[i] != d[i]) same = 1'b0;
      check(same, {tag, " R2 passthrough"}, same, 1);
      check({got[514], got[513], got[512]} == c, {tag, " R4 code bytes"},
            {got[514], got[513], got[512]}, c);
      same = 1'b1;
      for (int i = 515; i < 528; i++) if (got[i] != 8'hFF) same = 1'b0;
      check(same, {tag, " R3 padding"}, same, 1);
    end
    check(stat_count == 0, {tag, " R12 no write status"}, stat_count, 0);
  endtask

  // kind: 1 ok, 2 fixed, 3 bad
  task automatic do_read(input logic [7:0] frame[$], input logic [7:0] expd[$],
                         input int kind, input bit bp, input string tag);
    bit same;
    got.delete();
    stat_count = 0;
    out_during_load = 1'b0;
    bp_en = bp;
    loading = 1'b1;
    send_frame(1'b1, frame);
    loading = 1'b0;
    for (int w = 0; w < 3000 && stat_count == 0; w++) @(negedge clk);
    repeat (4) @(negedge clk);
    bp_en = 1'b0;
    check(!out_during_load, {tag, " R5 silent load"}, out_during_load, 0);
    check(stat_count == 1 && stat_kind == kind, {tag, " status"}, stat_kind, kind);
    if (kind == 3) begin
      check(got.size() == 0, {tag, " R9 no data"}, got.size(), 0);
    end else begin
      same = (got.size() == 512);
      if (same) for (int i = 0; i < 512; i++) if (got[i] != expd[i]) same = 1'b0;
      check(same, {tag, " data"}, same, 1);
      check(stat_cyc == last_fire_cyc + 1, {tag, " R6 status timing"}, stat_cyc, last_fire_cyc + 1);
    end
  endtask

  function automatic void build(input logic [7:0] d[$], input logic [7:0] pad,
                                output logic [7:0] f[$]);
    logic [23:0] c = ref_code(d);
    f = d;
    f.push_back(c[7:0]);
    f.push_back(c[15:8]);
    f.push_back(c[23:16]);
    for (int i = 3; i < 16; i++) f.push_back(pad);
  endfunction

  initial begin
    logic [7:0] f[$];
    for (int i = 0; i < 512; i++) dat_a.push_back(8'((i * 7 + 3) & 255));
    for (int i = 0; i < 512; i++) dat_b.push_back(8'($urandom));

    repeat (3) @(negedge clk);
    #2;
    check(!out_valid && !in_ready && !st_ok && !st_fixed && !st_bad, "R1 in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    check(!out_valid && !in_ready && !st_ok && !st_fixed && !st_bad, "R1 after reset", out_valid, 0);

    do_write(dat_a, 1'b0, "W1");
    do_write(dat_b, 1'b1, "W2 R10");

    build(dat_a, 8'hFF, f);
    do_read(f, dat_a, 1, 1'b0, "R6 R12 clean");

    build(dat_a, 8'hFF, f);
    f[300][5] = ~f[300][5];
    do_read(f, dat_a, 2, 1'b0, "R7 mid");

    build(dat_b, 8'hFF, f);
    f[0][0] = ~f[0][0];
    do_read(f, dat_b, 2, 1'b1, "R7 first");

    build(dat_b, 8'hFF, f);
    f[511][7] = ~f[511][7];
    do_read(f, dat_b, 2, 1'b0, "R7 last");

    build(dat_a, 8'hFF, f);
    f[513][3] = ~f[513][3];
    do_read(f, dat_a, 2, 1'b0, "R8 check bit");

    build(dat_a, 8'hFF, f);
    f[10][1] = ~f[10][1];
    f[20][2] = ~f[20][2];
    do_read(f, dat_a, 3, 1'b0, "R9 double");

    build(dat_b, 8'h5A, f);
    do_read(f, dat_b, 1, 1'b1, "R11 pad garbage");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule